// File: doc/BRIEF.md
# Byte-Bus Double-Buffered DAC Loader

This block sits between an 8-bit processor write bus and the 12-bit input register of a digital-to-analog converter. A 12-bit code needs two bus writes to two adjacent addresses. The first write only fills a 4-bit intermediate latch. The second write combines that nibble with the byte on the bus and commits the full 12-bit word to the converter in one step. Because of this, the converter never sees a word made of new high bits and stale low bits.

A static input chooses where the nibble sits. In right-justified placement it is the most significant part of the word. In left-justified placement it is the least significant part. A second static input says whether the processor's value is straight binary or two's complement. The block turns either one into the complementary coding the converter expects.

Each commit drives a new code onto a parallel bus and pulses an active-low register-enable strobe. The strobe stays low for a cycle count derived from the clock frequency and the converter's minimum pulse width and data setup time. A ready output goes low for the length of the pulse, and writes are refused while it is low.

Top module: `bytebus_dac_loader`

## Requirements
- R1: Only an accepted write with `wr_addr`=1 changes `dac_code`. An accepted write with `wr_addr`=0 leaves `dac_code` and `dac_le_n` unchanged.
- R2: With `left_just`=0, a commit forms word[11:8] from the latched byte0[3:0] and word[7:0] from the committing byte. byte0[7:4] is ignored.
- R3: With `left_just`=1, a commit forms word[3:0] from the latched byte0[7:4] and word[11:4] from the committing byte. byte0[3:0] is ignored.
- R4: With `twos_mode`=0 (straight binary), `dac_code` is the bitwise inverse of the word, so 0 gives 0xFFF and 0xFFF gives 0x000.
- R5: With `twos_mode`=1 (two's complement), `dac_code` is the bitwise inverse of the word with bit 11 flipped first, so 0x000 gives 0x7FF and 0x800 gives 0xFFF.
- R6: `dac_le_n` goes low in the cycle after the commit edge and stays low for exactly LOW_CYC cycles. LOW_CYC is the larger of ceil(PULSE_NS*CLK_MHZ/1000) and ceil(SETUP_NS*CLK_MHZ/1000), and at least 1. `dac_code` does not change while `dac_le_n` is low.
- R7: `ready` is low exactly while `dac_le_n` is low. A write presented while `ready` is low has no effect on the latch, the flag or the code.
- R8: A commit with no byte-0 write since the previous commit uses the last latched nibble. After reset that nibble is zero.
- R9: `nib_fresh` goes high after an accepted `wr_addr`=0 write and goes low after a commit.
- R10: After reset, `dac_code` is the zero-volt code for the selected coding (0xFFF straight, 0x7FF two's complement), `dac_le_n`=1, `ready`=1 and `nib_fresh`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 1 | 0 = nibble byte, 1 = committing byte |
| wr_data | input | 8 | Write data byte |
| left_just | input | 1 | Static nibble placement: 0 right-justified, 1 left-justified |
| twos_mode | input | 1 | Static input coding: 0 straight binary, 1 two's complement |
| ready | output | 1 | High when writes are accepted |
| dac_code | output | 12 | Complementary-coded code bus to the converter |
| dac_le_n | output | 1 | Active-low register-enable strobe |
| nib_fresh | output | 1 | Latch refreshed since the last commit |

## Verification
The bench builds the block with CLK_MHZ=250, PULSE_NS=8 and SETUP_NS=4, which gives a two-cycle strobe. With a pulse that short, every one of the 4096 words can be committed in both nibble placements and both codings within the cycle budget. Each word is written with the ignored nibble filled with other bits, which catches any swap or leak of nibbles. Directed passes then cover commits without a fresh nibble, writes refused during a pulse, and the reset code for each coding.

// File: rtl/dacld_pkg.sv
package dacld_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 12;
  localparam int NIB_W  = CODE_W - BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [NIB_W-1:0]  nib_t;

  typedef enum logic {LAYOUT_RIGHT = 1'b0, LAYOUT_LEFT = 1'b1} layout_e;
  typedef enum logic {CODING_BIN = 1'b0, CODING_TWOS = 1'b1} coding_e;

  // Nibble taken from the first byte for a given placement.
  function automatic nib_t pick_nibble(input byte_t b, input layout_e lay);
    if (lay == LAYOUT_LEFT) return b[BYTE_W-1 -: NIB_W];
    return b[NIB_W-1:0];
  endfunction

  // Full word from latched nibble and committing byte.
  function automatic code_t assemble(input nib_t n, input byte_t b, input layout_e lay);
    if (lay == LAYOUT_LEFT) return {b, n};
    return {n, b};
  endfunction

  // Complementary coding seen by the converter.
  function automatic code_t encode(input code_t w, input coding_e cod);
    code_t t;
    t = w;
    if (cod == CODING_TWOS) t[CODE_W-1] = ~t[CODE_W-1];
    return ~t;
  endfunction

  // Cycles needed to cover a time in ns at a clock in MHz, rounded up.
  function automatic int ns_to_cycles(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction
endpackage

// File: rtl/dacld_nibble_latch.sv
module dacld_nibble_latch
  import dacld_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  logic    clear,
  input  byte_t   byte_in,
  input  layout_e layout,
  output nib_t    nib_q,
  output logic    fresh_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nib_q   <= '0;
      fresh_q <= 1'b0;
    end else begin
      if (load) begin
        nib_q   <= pick_nibble(byte_in, layout);
        fresh_q <= 1'b1;
      end else if (clear) begin
        fresh_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dacld_commit_reg.sv
module dacld_commit_reg
  import dacld_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  code_t   word_in,
  input  coding_e coding,
  output code_t   code_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    code_q <= encode('0, coding);
    else if (load) code_q <= encode(word_in, coding);
  end
endmodule

// File: rtl/dacld_strobe_gen.sv
module dacld_strobe_gen #(
  parameter int LOW_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic le_n,
  output logic busy
);
  localparam int CNT_W = (LOW_CYC > 1) ? $clog2(LOW_CYC) : 1;
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(LOW_CYC - 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      le_n   <= 1'b1;
      remain <= '0;
    end else if (fire) begin
      le_n   <= 1'b0;
      remain <= LOAD_V;
    end else if (!le_n) begin
      if (remain == '0) le_n <= 1'b1;
      else              remain <= remain - 1'b1;
    end
  end

  assign busy = ~le_n;
endmodule

// File: rtl/bytebus_dac_loader.sv
module bytebus_dac_loader
  import dacld_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int PULSE_NS = 60,
  parameter int SETUP_NS = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              left_just,
  input  logic              twos_mode,
  output logic              ready,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_le_n,
  output logic              nib_fresh
);
  localparam int PULSE_CYC = ns_to_cycles(PULSE_NS, CLK_MHZ);
  localparam int SETUP_CYC = ns_to_cycles(SETUP_NS, CLK_MHZ);
  localparam int SPAN_CYC  = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
  localparam int LOW_CYC   = (SPAN_CYC < 1) ? 1 : SPAN_CYC;

  layout_e lay;
  coding_e cod;
  logic    busy;
  logic    accept;
  logic    nib_evt;
  logic    commit_evt;
  nib_t    nib_q;
  code_t   word;

  assign lay        = layout_e'(left_just);
  assign cod        = coding_e'(twos_mode);
  assign ready      = ~busy;
  assign accept     = wr_en & ready;
  assign nib_evt    = accept & ~wr_addr;
  assign commit_evt = accept & wr_addr;
  assign word       = assemble(nib_q, wr_data, lay);

  dacld_nibble_latch u_nib (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (nib_evt),
    .clear   (commit_evt),
    .byte_in (wr_data),
    .layout  (lay),
    .nib_q   (nib_q),
    .fresh_q (nib_fresh)
  );

  dacld_commit_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (commit_evt),
    .word_in (word),
    .coding  (cod),
    .code_q  (dac_code)
  );

  dacld_strobe_gen #(.LOW_CYC(LOW_CYC)) u_stb (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (commit_evt),
    .le_n  (dac_le_n),
    .busy  (busy)
  );
endmodule

// File: rtl/dacld_checker.sv
module dacld_checker #(
  parameter int CODE_W  = 12,
  parameter int LOW_CYC = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              dac_le_n,
  input logic              nib_fresh,
  input logic [CODE_W-1:0] dac_code,
  input logic              nib_evt,
  input logic              commit_evt
);
  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n)        low_run <= '0;
    else if (dac_le_n) low_run <= '0;
    else               low_run <= low_run + 16'd1;
  end

  // R1: the code bus moves only on a commit
  assert_code_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_evt |=> $stable(dac_code));

  // R6: strobe starts after the commit edge
  assert_strobe_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> !dac_le_n);

  // R6: strobe low for exactly LOW_CYC cycles
  assert_strobe_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_le_n) |-> (low_run == 16'(LOW_CYC)));

  // R6: code stable while strobe low
  assert_code_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_le_n && $past(!dac_le_n)) |-> $stable(dac_code));

  // R7: no commit is accepted while not ready
  assert_commit_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |-> ready);

  // R9: flag set by a nibble write, cleared by a commit
  assert_fresh_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nib_evt |=> nib_fresh);
  assert_fresh_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> !nib_fresh);
endmodule

bind bytebus_dac_loader dacld_checker #(.CODE_W(dacld_pkg::CODE_W), .LOW_CYC(LOW_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ready      (ready),
  .dac_le_n   (dac_le_n),
  .nib_fresh  (nib_fresh),
  .dac_code   (dac_code),
  .nib_evt    (nib_evt),
  .commit_evt (commit_evt)
);

// File: tb/bytebus_dac_loader_test.sv
module bytebus_dac_loader_test;
  localparam int EXP_LOW = 2; // 8 ns at 250 MHz

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       left_just = 1'b0;
  logic       twos_mode = 1'b0;
  logic        ready, dac_le_n, nib_fresh;
  logic [11:0] dac_code;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bytebus_dac_loader #(.CLK_MHZ(250), .PULSE_NS(8), .SETUP_NS(4)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .left_just(left_just), .twos_mode(twos_mode), .ready(ready),
    .dac_code(dac_code), .dac_le_n(dac_le_n), .nib_fresh(nib_fresh));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int expect_code(input int w, input bit twos);
    int v;
    v = twos ? ((w + 2048) % 4096) : w;
    return 4095 - v;
  endfunction

  task automatic do_reset(input bit lj, input bit tw);
    @(negedge clk);
    rst_n = 1'b0; left_just = lj; twos_mode = tw; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_write(input bit a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_pulse(input string req);
    repeat (EXP_LOW - 1) @(negedge clk);
    chk(!dac_le_n && !ready, req, {30'b0, dac_le_n, ready}, 0);
    @(negedge clk);
    chk(dac_le_n && ready, req, {30'b0, dac_le_n, ready}, 3);
  endtask

  initial begin
    int prev;
    int b0, b1, e;
    for (int cfg = 0; cfg < 4; cfg++) begin
      bit lj = cfg[0];
      bit tw = cfg[1];
      do_reset(lj, tw);
      prev = tw ? 12'h7FF : 12'hFFF;
      // R10: reset state
      chk(int'(dac_code) == prev, "R10 reset code", int'(dac_code), prev);
      chk(dac_le_n && ready && !nib_fresh, "R10 reset flags",
          {29'b0, dac_le_n, ready, nib_fresh}, 6);
      for (int w = 0; w < 4096; w++) begin
        if (!lj) begin
          b0 = ((w >> 8) & 15) | ((w & 15) << 4); // upper nibble junk (R2)
          b1 = w & 255;
        end else begin
          b0 = ((w & 15) << 4) | ((w >> 8) & 15); // lower nibble junk (R3)
          b1 = w >> 4;
        end
        e = expect_code(w, tw);
        bus_write(1'b0, b0);
        // R1 no change on byte-0 write; R9 flag set
        chk(int'(dac_code) == prev && dac_le_n, "R1 byte0 no commit", int'(dac_code), prev);
        chk(nib_fresh, "R9 fresh set", int'(nib_fresh), 1);
        bus_write(1'b1, b1);
        chk(int'(dac_code) == e, lj ? (tw ? "R3 R5 commit" : "R3 R4 commit")
                                    : (tw ? "R2 R5 commit" : "R2 R4 commit"),
            int'(dac_code), e);
        chk(!nib_fresh, "R9 fresh cleared", int'(nib_fresh), 0);
        finish_pulse("R6 R7 strobe");
        chk(int'(dac_code) == e, "R6 code held", int'(dac_code), e);
        prev = e;
      end
    end

    // R8: commit without byte 0 after reset uses nibble zero
    do_reset(1'b0, 1'b0);
    bus_write(1'b1, 8'h34);
    chk(int'(dac_code) == expect_code(12'h034, 0), "R8 zero nibble", int'(dac_code), expect_code(12'h034, 0));
    finish_pulse("R6 pulse");
    bus_write(1'b0, 8'h0A);
    bus_write(1'b1, 8'h55);
    finish_pulse("R6 pulse");
    bus_write(1'b1, 8'h66);
    chk(int'(dac_code) == expect_code(12'hA66, 0), "R8 reuse nibble", int'(dac_code), expect_code(12'hA66, 0));
    chk(!nib_fresh, "R9 flag stays low", int'(nib_fresh), 0);
    // R7: commit write during pulse ignored
    bus_write(1'b1, 8'h77);
    chk(!dac_le_n, "R7 pulse continues", int'(dac_le_n), 0);
    @(negedge clk);
    chk(dac_le_n && ready, "R7 pulse not extended", int'(dac_le_n), 1);
    chk(int'(dac_code) == expect_code(12'hA66, 0), "R7 busy commit ignored", int'(dac_code), expect_code(12'hA66, 0));
    // R7: nibble write during pulse ignored
    bus_write(1'b1, 8'h11);
    bus_write(1'b0, 8'h03);
    chk(!nib_fresh, "R7 busy nibble flag", int'(nib_fresh), 0);
    @(negedge clk);
    bus_write(1'b1, 8'h22);
    chk(int'(dac_code) == expect_code(12'hA22, 0), "R7 busy nibble ignored", int'(dac_code), expect_code(12'hA22, 0));
    finish_pulse("R6 pulse");
    // R10: reset with two's complement returns the mid code
    do_reset(1'b1, 1'b1);
    chk(int'(dac_code) == 12'h7FF, "R10 twos reset", int'(dac_code), 12'h7FF);
    bus_write(1'b1, 8'h80); // word 0x800 with nibble 0 -> most negative
    chk(int'(dac_code) == 12'hFFF, "R5 most negative", int'(dac_code), 12'hFFF);
    finish_pulse("R6 pulse");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule